// File: doc/BRIEF.md
# Phase-Tracking Loop Controller

This block closes the control loop of a digitally controlled clock synthesiser. Each frequency-error sample from a counting detector can first be smoothed by an optional first-order recursive filter. It then updates two clipped accumulators: a first integral, and a second integral that sums the first. The second integral tracks phase error, so the loop can pull phase to zero even though the detector only reports frequency.

The proportional, integral and double-integral terms are scaled by programmable signed gains. All values are signed fixed point with 16 fraction bits in a 32-bit word. The three products are summed at full width. The integer part of that sum offsets a mid-range centre index, and the result is saturated into an unsigned control word of `CTRL_W` bits. That word typically indexes a monotonic table of oscillator settings.

Top module: `loop_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `ctrl_o` equals the centre index 2^(CTRL_W-1) (512 by default), `ctrl_valid_o` is 0, and the filter state and both accumulators are zero.
- R2: A sample is taken only on a clock edge with `err_valid_i` = 1. `ctrl_valid_o` is 1 for exactly the one cycle after the second edge following that sample. With `err_valid_i` = 0, `err_i` has no effect, and `ctrl_o` keeps its value whenever `ctrl_valid_o` is 0.
- R3: With the integral gains at zero, `ctrl_o` = centre + floor(kp * e / 2^32), where e is the filtered error and kp is a signed 32-bit value with 16 fraction bits.
- R4: The integral accumulator adds each filtered error sample: i_new = i + e.
- R5: The double-integral accumulator adds the already-updated integral: d_new = d + i_new.
- R6: The integral accumulator is clipped to the range [-L, +L], where L is the unsigned `windup_lim_i` value with 16 fraction bits.
- R7: The double-integral accumulator is clipped to the same range [-L, +L]. Both clips can take effect on the same sample.
- R8: The control word saturates at 0 and at 2^CTRL_W - 1 and never wraps.
- R9: When `lpf_en_i` = 1, the filtered error is y + ((x - y) >>> LPF_SHIFT), where LPF_SHIFT is 2 by default and y is the stored state. When `lpf_en_i` = 0, the filtered error is x. In both cases the stored state takes the filtered value on each sample.
- R10: `ctrl_o` = centre + floor((kp*e + ki*i + kii*d) / 2^32), using the post-update accumulators and a sum of at least 64 bits, then saturated as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | ERR_W | Signed frequency error, 16 fraction bits |
| err_valid_i | input | 1 | Error sample strobe |
| lpf_en_i | input | 1 | Enables smoothing of the error input |
| kp_i | input | ERR_W | Proportional gain, signed, 16 fraction bits |
| ki_i | input | ERR_W | Integral gain, signed, 16 fraction bits |
| kii_i | input | ERR_W | Double-integral gain, signed, 16 fraction bits |
| windup_lim_i | input | ERR_W-1 | Accumulator clip magnitude, 16 fraction bits |
| ctrl_o | output | CTRL_W | Saturated control word |
| ctrl_valid_o | output | 1 | Control word update strobe |

## Verification
The integral clip and the double-integral clip can act on the same sample. A small limit with a large error drives both accumulators past the limit on one strobe, and a large negative error then drives the integral to the opposite rail while the double integral comes back in range. The expected word is formed from both clipped values at once. A wrong clip in either accumulator changes the index.

// File: rtl/loop_ctrl_pkg.sv
package loop_ctrl_pkg;
  localparam int FRAC_W    = 16;
  localparam int OUT_SHIFT = 2 * FRAC_W; // gain*term product carries twice the fraction bits
endpackage

// File: rtl/loop_ctrl_lpf.sv
module loop_ctrl_lpf #(
  parameter int W     = 32,
  parameter int SHIFT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                valid_i,
  input  logic signed [W-1:0] x_i,
  output logic signed [W-1:0] f_o
);
  localparam int SW = W + 1;

  if (SHIFT == 0) begin : g_bypass
    assign f_o = x_i;
  end else begin : g_iir
    logic signed [W-1:0]  y_q;
    logic signed [SW-1:0] diff;
    logic signed [SW-1:0] step;
    logic signed [W-1:0]  smooth;

    assign diff   = SW'(x_i) - SW'(y_q);
    assign step   = diff >>> SHIFT;
    assign smooth = y_q + step[W-1:0];
    assign f_o    = en_i ? smooth : x_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      y_q <= '0;
      else if (valid_i) y_q <= f_o;
    end
  end
endmodule

// File: rtl/loop_ctrl_clipadd.sv
module loop_ctrl_clipadd #(
  parameter int W = 32
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  input  logic        [W-2:0] lim_i,
  output logic signed [W-1:0] y_o
);
  localparam int SW = W + 1;

  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] hi;
  logic signed [SW-1:0] lo;

  assign sum = SW'(a_i) + SW'(b_i);
  assign hi  = {2'b00, lim_i};
  assign lo  = -hi;

  always_comb begin
    if (sum > hi)      y_o = hi[W-1:0];
    else if (sum < lo) y_o = lo[W-1:0];
    else               y_o = sum[W-1:0];
  end
endmodule

// File: rtl/loop_ctrl_mix.sv
module loop_ctrl_mix
  import loop_ctrl_pkg::*;
#(
  parameter int W      = 32,
  parameter int CTRL_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_i,
  input  logic signed [W-1:0] e_i,
  input  logic signed [W-1:0] i_i,
  input  logic signed [W-1:0] d_i,
  input  logic signed [W-1:0] kp_i,
  input  logic signed [W-1:0] ki_i,
  input  logic signed [W-1:0] kii_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic                ctrl_valid_o
);
  localparam int PROD_W   = 2 * W;
  localparam int SUM_W    = PROD_W + 2;
  localparam int CTRL_MAX = (1 << CTRL_W) - 1;
  localparam int CENTER   = 1 << (CTRL_W - 1);

  logic signed [PROD_W-1:0] p_term, i_term, d_term;
  logic signed [SUM_W-1:0]  acc, idx;
  logic [CTRL_W-1:0]        sat;

  assign p_term = PROD_W'(kp_i)  * PROD_W'(e_i);
  assign i_term = PROD_W'(ki_i)  * PROD_W'(i_i);
  assign d_term = PROD_W'(kii_i) * PROD_W'(d_i);
  assign acc    = SUM_W'(p_term) + SUM_W'(i_term) + SUM_W'(d_term);
  assign idx    = (acc >>> OUT_SHIFT) + SUM_W'(CENTER);

  always_comb begin
    if (idx < 0)                      sat = '0;
    else if (idx > SUM_W'(CTRL_MAX))  sat = '1;
    else                              sat = idx[CTRL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o       <= CTRL_W'(CENTER);
      ctrl_valid_o <= 1'b0;
    end else begin
      ctrl_valid_o <= upd_i;
      if (upd_i) ctrl_o <= sat;
    end
  end
endmodule

// File: rtl/loop_ctrl.sv
module loop_ctrl #(
  parameter int ERR_W     = 32,
  parameter int CTRL_W    = 10,
  parameter int LPF_SHIFT = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    err_valid_i,
  input  logic                    lpf_en_i,
  input  logic signed [ERR_W-1:0] kp_i,
  input  logic signed [ERR_W-1:0] ki_i,
  input  logic signed [ERR_W-1:0] kii_i,
  input  logic        [ERR_W-2:0] windup_lim_i,
  output logic [CTRL_W-1:0]       ctrl_o,
  output logic                    ctrl_valid_o
);
  localparam int N_INT = 2;

  logic signed [ERR_W-1:0] filt;
  logic signed [ERR_W-1:0] e_q;
  logic                    upd_q;
  logic signed [ERR_W-1:0] acc_q  [N_INT];
  logic signed [ERR_W-1:0] acc_nx [N_INT];
  logic signed [ERR_W-1:0] add_v  [N_INT];
  logic signed [ERR_W-1:0] integ_q, dint_q;

  loop_ctrl_lpf #(.W(ERR_W), .SHIFT(LPF_SHIFT)) u_lpf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (lpf_en_i),
    .valid_i (err_valid_i),
    .x_i     (err_i),
    .f_o     (filt)
  );

  // stage k integrates the freshly clipped output of stage k-1
  for (genvar k = 0; k < N_INT; k++) begin : g_int
    if (k == 0) begin : g_first
      assign add_v[k] = filt;
    end else begin : g_chain
      assign add_v[k] = acc_nx[k-1];
    end

    loop_ctrl_clipadd #(.W(ERR_W)) u_add (
      .a_i   (acc_q[k]),
      .b_i   (add_v[k]),
      .lim_i (windup_lim_i),
      .y_o   (acc_nx[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          acc_q[k] <= '0;
      else if (err_valid_i) acc_q[k] <= acc_nx[k];
    end
  end

  assign integ_q = acc_q[0];
  assign dint_q  = acc_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q   <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= err_valid_i;
      if (err_valid_i) e_q <= filt;
    end
  end

  loop_ctrl_mix #(.W(ERR_W), .CTRL_W(CTRL_W)) u_mix (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_i        (upd_q),
    .e_i          (e_q),
    .i_i          (integ_q),
    .d_i          (dint_q),
    .kp_i         (kp_i),
    .ki_i         (ki_i),
    .kii_i        (kii_i),
    .ctrl_o       (ctrl_o),
    .ctrl_valid_o (ctrl_valid_o)
  );
endmodule

// File: rtl/loop_ctrl_chk.sv
module loop_ctrl_chk #(
  parameter int ERR_W  = 32,
  parameter int CTRL_W = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    err_valid_i,
  input logic        [ERR_W-2:0] windup_lim_i,
  input logic signed [ERR_W-1:0] integ_q,
  input logic signed [ERR_W-1:0] dint_q,
  input logic [CTRL_W-1:0]       ctrl_o,
  input logic                    ctrl_valid_o
);
  logic signed [ERR_W:0] lim_ext, i_ext, d_ext;
  assign lim_ext = {2'b00, windup_lim_i};
  assign i_ext   = {integ_q[ERR_W-1], integ_q};
  assign d_ext   = {dint_q[ERR_W-1], dint_q};

  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_i |=> ##1 ctrl_valid_o); // R2
  AST_VALID_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_valid_o |-> $past(err_valid_i, 2)); // R2
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_valid_o |-> $stable(ctrl_o)); // R2
  AST_IDLE_NO_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_valid_i |=> ($stable(integ_q) && $stable(dint_q))); // R2
  AST_INT_CLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_valid_i) |-> (i_ext <= $past(lim_ext) && i_ext >= -$past(lim_ext))); // R6
  AST_DINT_CLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_valid_i) |-> (d_ext <= $past(lim_ext) && d_ext >= -$past(lim_ext))); // R7
endmodule

bind loop_ctrl loop_ctrl_chk #(.ERR_W(ERR_W), .CTRL_W(CTRL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .err_valid_i  (err_valid_i),
  .windup_lim_i (windup_lim_i),
  .integ_q      (integ_q),
  .dint_q       (dint_q),
  .ctrl_o       (ctrl_o),
  .ctrl_valid_o (ctrl_valid_o)
);

// File: tb/sim_loop_ctrl.sv
module sim_loop_ctrl;
  localparam int     ERR_W  = 32;
  localparam int     CTRL_W = 10;
  localparam int     SHIFT  = 2;
  localparam longint CENTER = 512;
  localparam longint CMAX   = 1023;
  localparam longint ONE    = 65536;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                    rst_n = 1'b0;
  logic signed [ERR_W-1:0] err = '0;
  logic                    err_vld = 1'b0;
  logic                    lpf_en = 1'b0;
  logic signed [ERR_W-1:0] kp = '0, ki = '0, kii = '0;
  logic        [ERR_W-2:0] lim = '0;
  logic [CTRL_W-1:0]       ctrl;
  logic                    ctrl_vld;

  loop_ctrl #(.ERR_W(ERR_W), .CTRL_W(CTRL_W), .LPF_SHIFT(SHIFT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .err_valid_i(err_vld),
    .lpf_en_i(lpf_en), .kp_i(kp), .ki_i(ki), .kii_i(kii),
    .windup_lim_i(lim), .ctrl_o(ctrl), .ctrl_valid_o(ctrl_vld)
  );

  int     n_cmp = 0, n_bad = 0;
  bit     done = 1'b0;
  longint m_y = 0, m_i = 0, m_d = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clip(input longint v, input longint l);
    if (v > l) return l;
    if (v < -l) return -l;
    return v;
  endfunction

  function automatic longint model_step(input longint x);
    longint f, s, l;
    l = longint'(lim);
    f = lpf_en ? m_y + ((x - m_y) >>> SHIFT) : x;
    m_y = f;
    m_i = clip(m_i + f, l);
    m_d = clip(m_d + m_i, l);
    s = longint'(kp) * f + longint'(ki) * m_i + longint'(kii) * m_d;
    s = (s >>> 32) + CENTER;
    if (s < 0) s = 0;
    if (s > CMAX) s = CMAX;
    return s;
  endfunction

  task automatic send(input longint x, input string req);
    longint exp;
    @(negedge clk);
    err = x[ERR_W-1:0];
    err_vld = 1'b1;
    exp = model_step(x);
    @(posedge clk);
    @(negedge clk);
    err_vld = 1'b0;
    chk(ctrl_vld == 1'b0, "R2 early valid", longint'(ctrl_vld), 0);
    @(posedge clk);
    @(negedge clk);
    chk(ctrl_vld == 1'b1, "R2 valid", longint'(ctrl_vld), 1);
    chk(longint'(ctrl) == exp, req, longint'(ctrl), exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    err_vld = 1'b0;
    rst_n = 1'b0;
    m_y = 0; m_i = 0; m_d = 0;
    repeat (2) @(negedge clk);
    chk(longint'(ctrl) == CENTER && !ctrl_vld, "R1 in reset", longint'(ctrl), CENTER);
    rst_n = 1'b1;
  endtask

  task automatic set_g(input longint p, input longint i, input longint ii, input longint l, input bit f);
    kp = p[ERR_W-1:0]; ki = i[ERR_W-1:0]; kii = ii[ERR_W-1:0];
    lim = l[ERR_W-2:0]; lpf_en = f;
  endtask

  task automatic t_reset();
    do_reset();
    repeat (2) @(negedge clk);
    chk(longint'(ctrl) == CENTER, "R1 center", longint'(ctrl), CENTER);
    chk(ctrl_vld == 1'b0, "R1 valid low", longint'(ctrl_vld), 0);
  endtask

  task automatic t_prop();
    do_reset();
    set_g(ONE, 0, 0, 100 * ONE, 0);
    send(688128, "R3 +10.5");
    send(-212992, "R3 -3.25");
    send(0, "R3 zero");
  endtask

  task automatic t_idle();
    logic [CTRL_W-1:0] hold;
    do_reset();
    set_g(0, ONE, 0, 100 * ONE, 0);
    send(3 * ONE, "R2 first sample");
    hold = ctrl;
    @(negedge clk);
    err = 40 * ONE;
    repeat (5) @(negedge clk);
    chk(ctrl == hold && !ctrl_vld, "R2 idle hold", longint'(ctrl), longint'(hold));
    send(0, "R2 ignored input");
  endtask

  task automatic t_integ();
    do_reset();
    set_g(0, ONE, 0, 100 * ONE, 0);
    send(2 * ONE, "R4 step1");
    send(2 * ONE, "R4 step2");
    send(-5 * ONE, "R4 step3");
  endtask

  task automatic t_dint();
    do_reset();
    set_g(0, 0, ONE, 100 * ONE, 0);
    send(ONE, "R5 d1");
    send(ONE, "R5 d3");
    send(ONE, "R5 d6");
  endtask

  task automatic t_clip();
    do_reset();
    set_g(0, ONE, ONE, 5 * ONE, 0);
    send(4 * ONE, "R6 below limit");
    send(4 * ONE, "R7 both clip");
    send(-20 * ONE, "R6 negative clip");
    send(-20 * ONE, "R7 negative clip");
  endtask

  task automatic t_sat();
    do_reset();
    set_g(100 * ONE, 0, 0, 100 * ONE, 0);
    send(10 * ONE, "R8 upper");
    send(-10 * ONE, "R8 lower");
  endtask

  task automatic t_lpf();
    do_reset();
    set_g(ONE, 0, 0, 100 * ONE, 1);
    send(8 * ONE, "R9 first");
    send(8 * ONE, "R9 second");
    lpf_en = 1'b0;
    send(8 * ONE, "R9 bypass");
    lpf_en = 1'b1;
    send(-8 * ONE, "R9 after bypass");
  endtask

  task automatic t_mix();
    do_reset();
    set_g(32768, 16384, 4096, 50 * ONE, 1);
    send(3 * ONE, "R10 a");
    send(-98304, "R10 b");
    send(475136, "R10 c");
    send(49152, "R10 d");
    send(-4 * ONE, "R10 e");
    send(30 * ONE, "R10 f");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prop();
    t_idle();
    t_integ();
    t_dint();
    t_clip();
    t_sat();
    t_lpf();
    t_mix();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule